// File: doc/BRIEF.md
# Source Operand Mode Decoder

This combinational block sits in the decode stage of a 16-bit microcontroller-style CPU. It takes the source register number, the two-bit source mode code and the byte/word flag of an instruction. From these it works out how the source operand will be fetched. It reports an effective-mode code and says whether an extension word has to be read from the instruction stream. It also tells the datapath whether a base register is read and how far that register advances after the access. When the operand comes from a hard-wired constant, it supplies the constant value.

Two register numbers are special. Register 3 never names a storage location: all four of its mode codes produce constants. Register 2 gives absolute addressing (base value zero) with code 01, and the constants 4 and 8 with codes 10 and 11. Register 0, the program counter, turns code 01 into PC-relative addressing and code 11 into immediate mode. The block also checks the destination mode code. Only register and indexed destinations are legal; any other code raises a flag. Indexed destinations request an extension word.

Top module: `src_mode_decoder`

## Requirements
- R1: With mode code 00, a register other than 3 gives eff_mode 0 (register) with reg_read 1, need_ext 0, post_inc 0, const_valid 0 and const_val 0.
- R2: With mode code 01, a register other than 0, 2 and 3 gives eff_mode 1 (indexed) with need_ext 1, reg_read 1 and post_inc 0.
- R3: Register 2 with mode code 01 gives eff_mode 2 (absolute) with need_ext 1 and reg_read 0, because the base value is zero.
- R4: Register 0 with mode code 01 gives eff_mode 3 (PC-relative) with need_ext 1 and reg_read 1.
- R5: With mode code 10, a register other than 2 and 3 gives eff_mode 4 (indirect) with need_ext 0, reg_read 1 and post_inc 0.
- R6: With mode code 11, a register other than 0, 2 and 3 gives eff_mode 5 (post-increment) with need_ext 0 and reg_read 1. post_inc is 1 when byte_op is 1 and 2 when byte_op is 0.
- R7: Register 0 with mode code 11 gives eff_mode 6 (immediate) with need_ext 1, reg_read 1 and post_inc 2, whatever byte_op is.
- R8: Register 2 with mode codes 10 and 11 gives eff_mode 7 (constant) with const_valid 1 and const_val 4 and 8 respectively, need_ext 0, reg_read 0 and post_inc 0.
- R9: Register 3 with mode codes 00, 01, 10 and 11 gives eff_mode 7 with const_valid 1 and const_val 0, 1, 2 and 0xFFFF respectively, need_ext 0, reg_read 0 and post_inc 0.
- R10: Destination code 00 (register) gives dst_illegal 0 and dst_need_ext 0. Code 01 (indexed) gives dst_illegal 0 and dst_need_ext 1. Codes 10 and 11 give dst_illegal 1 and dst_need_ext 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_reg | input | 4 | Source register number |
| src_as | input | 2 | Source mode code |
| byte_op | input | 1 | 1 for a byte access, 0 for a word access |
| dst_mode | input | 2 | Destination mode code |
| eff_mode | output | 3 | Effective source mode code (0..7) |
| need_ext | output | 1 | The source needs an extension word |
| reg_read | output | 1 | The source reads its base register |
| post_inc | output | 2 | Amount added to the base register after the access |
| const_valid | output | 1 | The operand is a generated constant |
| const_val | output | 16 | Generated constant, 0 when none applies |
| dst_illegal | output | 1 | Destination mode code is not register or indexed |
| dst_need_ext | output | 1 | The destination needs an extension word |

## Verification
Whenever the inputs settle, the embedded assertions check that the sub-decoders agree with one another. A constant must never request an extension word or a register read. The constant flag must match the constant mode code. A post-increment must occur only with post-increment or immediate modes. Absolute mode must not read a register, and an illegal destination must never request an extension word. Whether each register and mode pairing lands on the right code, the right constant value and the right byte-versus-word increment can only be shown by the scenarios. The bench sweeps every input combination against an independent model.

// File: rtl/src_mode_pkg.sv
package src_mode_pkg;

  typedef enum logic [2:0] {
    EM_REG   = 3'd0,
    EM_IDX   = 3'd1,
    EM_ABS   = 3'd2,
    EM_PCREL = 3'd3,
    EM_IND   = 3'd4,
    EM_AINC  = 3'd5,
    EM_IMM   = 3'd6,
    EM_CONST = 3'd7
  } eff_mode_e;

  typedef enum logic [1:0] {
    AS_DIRECT    = 2'd0,
    AS_OFFSET    = 2'd1,
    AS_DEREF     = 2'd2,
    AS_DEREF_INC = 2'd3
  } as_code_e;

endpackage

// File: rtl/sm_const_gen.sv
module sm_const_gen #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 4,
  parameter int CG_A   = 2,
  parameter int CG_B   = 3
) (
  input  logic [REG_W-1:0]  reg_num,
  input  logic [1:0]        as_code,
  output logic              hit,
  output logic [DATA_W-1:0] value
);
  import src_mode_pkg::*;

  logic sel_a;
  logic sel_b;

  assign sel_a = (reg_num == REG_W'(CG_A));
  assign sel_b = (reg_num == REG_W'(CG_B));

  always_comb begin
    hit   = 1'b0;
    value = '0;
    if (sel_b) begin
      hit = 1'b1;
      unique case (as_code_e'(as_code))
        AS_DIRECT:    value = '0;
        AS_OFFSET:    value = DATA_W'(1);
        AS_DEREF:     value = DATA_W'(2);
        AS_DEREF_INC: value = '1;
        default:      value = '0;
      endcase
    end else if (sel_a && as_code[1]) begin
      hit   = 1'b1;
      value = as_code[0] ? DATA_W'(8) : DATA_W'(4);
    end
  end

endmodule

// File: rtl/sm_mode_class.sv
module sm_mode_class #(
  parameter int REG_W  = 4,
  parameter int PC_IDX = 0,
  parameter int ABS_IX = 2,
  parameter int INC_W  = 2
) (
  input  logic [REG_W-1:0] reg_num,
  input  logic [1:0]       as_code,
  input  logic             byte_op,
  input  logic             const_hit,
  output logic [2:0]       mode,
  output logic             need_ext,
  output logic             reg_read,
  output logic [INC_W-1:0] post_inc
);
  import src_mode_pkg::*;

  localparam logic [INC_W-1:0] INC_BYTE = INC_W'(1);
  localparam logic [INC_W-1:0] INC_WORD = INC_W'(2);

  logic is_pc;
  logic is_abs_base;
  eff_mode_e m;

  assign is_pc       = (reg_num == REG_W'(PC_IDX));
  assign is_abs_base = (reg_num == REG_W'(ABS_IX));

  always_comb begin
    m        = EM_REG;
    need_ext = 1'b0;
    reg_read = 1'b1;
    post_inc = '0;
    if (const_hit) begin
      m        = EM_CONST;
      reg_read = 1'b0;
    end else begin
      unique case (as_code_e'(as_code))
        AS_DIRECT: m = EM_REG;
        AS_OFFSET: begin
          need_ext = 1'b1;
          if (is_abs_base) begin
            m        = EM_ABS;
            reg_read = 1'b0;
          end else if (is_pc) begin
            m = EM_PCREL;
          end else begin
            m = EM_IDX;
          end
        end
        AS_DEREF: m = EM_IND;
        AS_DEREF_INC: begin
          if (is_pc) begin
            m        = EM_IMM;
            need_ext = 1'b1;
            post_inc = INC_WORD;
          end else begin
            m        = EM_AINC;
            post_inc = byte_op ? INC_BYTE : INC_WORD;
          end
        end
        default: m = EM_REG;
      endcase
    end
  end

  assign mode = m;

endmodule

// File: rtl/sm_dst_check.sv
module sm_dst_check #(
  parameter int DM_W = 2
) (
  input  logic [DM_W-1:0] dst_code,
  output logic            illegal,
  output logic            need_ext
);
  localparam logic [DM_W-1:0] DM_REG = DM_W'(0);
  localparam logic [DM_W-1:0] DM_IDX = DM_W'(1);

  always_comb begin
    illegal  = 1'b1;
    need_ext = 1'b0;
    if (dst_code == DM_REG) begin
      illegal = 1'b0;
    end else if (dst_code == DM_IDX) begin
      illegal  = 1'b0;
      need_ext = 1'b1;
    end
  end

endmodule

// File: rtl/src_mode_decoder.sv
module src_mode_decoder #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 4,
  parameter int PC_IDX = 0,
  parameter int CG_A   = 2,
  parameter int CG_B   = 3
) (
  input  logic [REG_W-1:0]  src_reg,
  input  logic [1:0]        src_as,
  input  logic              byte_op,
  input  logic [1:0]        dst_mode,
  output logic [2:0]        eff_mode,
  output logic              need_ext,
  output logic              reg_read,
  output logic [1:0]        post_inc,
  output logic              const_valid,
  output logic [DATA_W-1:0] const_val,
  output logic              dst_illegal,
  output logic              dst_need_ext
);
  import src_mode_pkg::*;

  localparam int INC_W = 2;

  logic c_hit;

  sm_const_gen #(
    .DATA_W(DATA_W), .REG_W(REG_W), .CG_A(CG_A), .CG_B(CG_B)
  ) u_const (
    .reg_num(src_reg), .as_code(src_as), .hit(c_hit), .value(const_val)
  );

  sm_mode_class #(
    .REG_W(REG_W), .PC_IDX(PC_IDX), .ABS_IX(CG_A), .INC_W(INC_W)
  ) u_class (
    .reg_num(src_reg), .as_code(src_as), .byte_op(byte_op),
    .const_hit(c_hit), .mode(eff_mode), .need_ext(need_ext),
    .reg_read(reg_read), .post_inc(post_inc)
  );

  sm_dst_check #(.DM_W(2)) u_dst (
    .dst_code(dst_mode), .illegal(dst_illegal), .need_ext(dst_need_ext)
  );

  assign const_valid = c_hit;

  always_comb begin
    if (!$isunknown({src_reg, src_as, byte_op, dst_mode})) begin
      p_const_quiet_r9: assert (!(const_valid && (need_ext || reg_read)))
        else $error("constant operand requests fetch or register read");
      p_const_agree_r8: assert (const_valid == (eff_mode == EM_CONST))
        else $error("constant flag disagrees with mode code");
      p_inc_mode_r6: assert ((post_inc == '0) ||
                             (eff_mode == EM_AINC) || (eff_mode == EM_IMM))
        else $error("increment outside post-increment modes");
      p_abs_base_r3: assert ((eff_mode != EM_ABS) || (need_ext && !reg_read))
        else $error("absolute mode must fetch and not read a register");
      p_dst_excl_r10: assert (!(dst_illegal && dst_need_ext))
        else $error("illegal destination requested extension word");
      p_const_zero_r1: assert (const_valid || (const_val == '0))
        else $error("constant value leaks outside constant mode");
    end
  end

endmodule

// File: tb/src_mode_decoder_bench.sv
module src_mode_decoder_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  mode;
    logic        ext;
    logic        rd;
    logic [1:0]  inc;
    logic        cv;
    logic [15:0] cval;
    logic        dill;
    logic        dext;
  } exp_t;

  logic clk;
  logic [3:0]  src_reg;
  logic [1:0]  src_as;
  logic        byte_op;
  logic [1:0]  dst_mode;
  logic [2:0]  eff_mode;
  logic        need_ext, reg_read, const_valid, dst_illegal, dst_need_ext;
  logic [1:0]  post_inc;
  logic [15:0] const_val;

  exp_t  q_exp[$];
  string q_tag[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  src_mode_decoder u_src_mode_decoder (
    .src_reg(src_reg), .src_as(src_as), .byte_op(byte_op),
    .dst_mode(dst_mode), .eff_mode(eff_mode), .need_ext(need_ext),
    .reg_read(reg_read), .post_inc(post_inc), .const_valid(const_valid),
    .const_val(const_val), .dst_illegal(dst_illegal),
    .dst_need_ext(dst_need_ext)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(input int r, input int a, input bit b,
                                 input int d);
    exp_t e;
    e = '0;
    e.rd = 1'b1;
    if (r == 3) begin
      e.mode = 3'd7; e.cv = 1'b1; e.rd = 1'b0;
      e.cval = (a == 0) ? 16'h0000 : (a == 1) ? 16'h0001 :
               (a == 2) ? 16'h0002 : 16'hFFFF;
    end else if (r == 2 && a >= 2) begin
      e.mode = 3'd7; e.cv = 1'b1; e.rd = 1'b0;
      e.cval = (a == 2) ? 16'h0004 : 16'h0008;
    end else if (a == 0) begin
      e.mode = 3'd0;
    end else if (a == 1) begin
      e.ext = 1'b1;
      if (r == 2)      begin e.mode = 3'd2; e.rd = 1'b0; end
      else if (r == 0) e.mode = 3'd3;
      else             e.mode = 3'd1;
    end else if (a == 2) begin
      e.mode = 3'd4;
    end else if (r == 0) begin
      e.mode = 3'd6; e.ext = 1'b1; e.inc = 2'd2;
    end else begin
      e.mode = 3'd5; e.inc = b ? 2'd1 : 2'd2;
    end
    e.dill = (d >= 2);
    e.dext = (d == 1);
    return e;
  endfunction

  function automatic string tag_of(input int r, input int a, input int d);
    if (d != 0)           return "R10";
    if (r == 3)           return "R9";
    if (r == 2 && a >= 2) return "R8";
    if (a == 0)           return "R1";
    if (a == 1 && r == 2) return "R3";
    if (a == 1 && r == 0) return "R4";
    if (a == 1)           return "R2";
    if (a == 2)           return "R5";
    if (r == 0)           return "R7";
    return "R6";
  endfunction

  task automatic apply(input int r, input int a, input bit b, input int d);
    @(negedge clk);
    src_reg  = 4'(r);
    src_as   = 2'(a);
    byte_op  = b;
    dst_mode = 2'(d);
    q_exp.push_back(model(r, a, b, d));
    q_tag.push_back(tag_of(r, a, d));
  endtask

  always @(posedge clk) begin
    if (q_exp.size() > 0) begin
      exp_t  e;
      exp_t  act;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      act = {eff_mode, need_ext, reg_read, post_inc, const_valid, const_val,
             dst_illegal, dst_need_ext};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s reg=%0d as=%0d byte=%0b dst=%0d actual=%h expected=%h",
                 t, src_reg, src_as, byte_op, dst_mode, act, e);
      end
    end
  end

  initial begin
    src_reg = '0; src_as = '0; byte_op = 1'b0; dst_mode = '0;
    // initial pattern: register mode on R0, R1 check first
    apply(0, 0, 0, 0);
    // directed corner cases
    apply(3, 0, 0, 0);  // R9 constant zero, no register read
    apply(3, 3, 1, 0);  // R9 all-ones constant
    apply(2, 1, 0, 0);  // R3 absolute
    apply(2, 3, 1, 0);  // R8 constant 8
    apply(0, 3, 1, 0);  // R7 immediate ignores byte flag
    apply(5, 3, 1, 0);  // R6 byte increment
    apply(5, 3, 0, 0);  // R6 word increment
    apply(0, 1, 0, 0);  // R4 PC-relative
    apply(9, 1, 0, 0);  // R2 indexed
    apply(4, 2, 0, 0);  // R5 indirect
    apply(7, 0, 0, 2);  // R10 illegal destination
    apply(7, 0, 0, 1);  // R10 indexed destination
    // exhaustive sweep
    for (int d = 0; d < 4; d++)
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 4; a++)
          for (int r = 0; r < 16; r++)
            apply(r, a, b[0], d);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule